// File: doc/BRIEF.md
# Pulse High/Low Time Meter

This block measures how long a digital input stays high and how long it stays low. It counts ticks of a timebase, and the timebase is the block clock divided by a programmable ratio. The input is first synchronized into the clock domain. It is then sampled once per tick, and a change of the sampled level is treated as an edge.

At a falling edge, the length of the high phase that just ended is stored in the high-time register. At a rising edge, the length of the low phase is stored in the low-time register. A read strobe returns both values packed into a single word. A phase that runs longer than the counter can hold reads back as the all-ones value.

A write of zero on the write port is a clear command. The value it loads depends on the synchronized input level at that moment, so a reader can tell an input stuck low from an input stuck high when no edges ever arrive.

Top module: `pulse_meter`

## Requirements
- R1: After the asynchronous reset `rstN`, a read returns zero.
- R2: A read strobe on `rdEn` loads `rdData` at the next clock edge. Bits [CNT_W-1:0] hold the high-time count and bits [2*CNT_W-1:CNT_W] hold the low-time count.
- R3: On a falling edge of the input, the high-time register takes the number of ticks for which the input was high.
- R4: On a rising edge of the input, the low-time register takes the number of ticks for which the input was low.
- R5: One tick occurs every `tickDiv`+1 clock cycles, so `tickDiv` values 0 to 2^DIV_W-1 select division ratios of 1 to 2^DIV_W.
- R6: A write of all-zero data while the synchronized input is low sets the high time to 0 and the low time to all ones. Both values then persist while no edge occurs.
- R7: A write of all-zero data while the synchronized input is high sets the high time to all ones and the low time to 0.
- R8: A write of any nonzero data has no effect on either register.
- R9: When a read and a zero write happen in the same cycle, the read returns the values held just before the clear.
- R10: A phase longer than 2^CNT_W-1 ticks is reported as 2^CNT_W-1 (the phase counter saturates and does not wrap).
- R11: The phase counter restarts at every detected edge, so each captured value covers only its own phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock and timebase source |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | 1 | Asynchronous signal under measurement |
| tickDiv | input | DIV_W | Tick period minus one, in clock cycles |
| wrEn | input | 1 | Write strobe |
| wrData | input | 2*CNT_W | Write data; all zero means clear |
| rdEn | input | 1 | Read strobe |
| rdData | output | 2*CNT_W | Packed low-time (upper) and high-time (lower) counts |

## Verification
The bench builds the block with CNT_W = 10 and DIV_W = 3. The narrow counter lets a phase of about a thousand ticks reach saturation in R10. The 3-bit divisor lets random trials cover every ratio from 1 to 8. Because phase lengths are driven as whole multiples of the tick period, each expected capture equals the requested tick count exactly, whatever the prescaler alignment.

// File: rtl/pulse_meter_pkg.sv
package pulse_meter_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic tick;      // timebase tick
    logic rise;      // sampled input went low -> high on this tick
    logic fall;      // sampled input went high -> low on this tick
    logic clear;     // zero write seen this cycle
    logic clearLvl;  // synchronized input level at the clear
  } meter_strobe_t;
endpackage

// File: rtl/pulse_meter_ctrl.sv
module pulse_meter_ctrl
  import pulse_meter_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sigIn,
  input  logic [DIV_W-1:0]  tickDiv,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output meter_strobe_t     strobe
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] syncQ;
  logic              syncLvl;
  logic              lvlQ;
  logic [DIV_W-1:0]  preCnt;
  logic              tick;

  assign syncLvl = syncQ[SYNC_N-1];
  assign tick    = (preCnt >= tickDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      lvlQ   <= 1'b0;
      preCnt <= '0;
    end else begin
      syncQ  <= {syncQ[SYNC_N-2:0], sigIn};
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) lvlQ <= syncLvl;
    end
  end

  always_comb begin
    strobe.tick     = tick;
    strobe.rise     = tick &  syncLvl & ~lvlQ;
    strobe.fall     = tick & ~syncLvl &  lvlQ;
    strobe.clear    = wrEn && (wrData == '0);
    strobe.clearLvl = syncLvl;
  end

  // R5: with a nonzero divisor, ticks never fall on back-to-back cycles
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && tickDiv != '0) |=> (!tick || tickDiv == '0));

  // R3/R4: a detected edge always changes the level held for the tick domain
  p_edge_moves_level_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rise || strobe.fall) |=> (lvlQ != $past(lvlQ)));
endmodule

// File: rtl/pulse_meter_dp.sv
module pulse_meter_dp
  import pulse_meter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  meter_strobe_t        strobe,
  input  logic                 rdEn,
  output logic [2*CNT_W-1:0]   rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]   phaseCnt;
  logic [CNT_W-1:0]   phaseNext;
  logic [CNT_W-1:0]   highReg;
  logic [CNT_W-1:0]   lowReg;
  logic [2*CNT_W-1:0] rdQ;

  // Saturating increment: an over-long phase sticks at the maximum.
  assign phaseNext = (phaseCnt == CNT_MAX) ? CNT_MAX : phaseCnt + 1'b1;
  assign rdData    = rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      highReg  <= '0;
      lowReg   <= '0;
      rdQ      <= '0;
    end else begin
      if (strobe.clear) begin
        phaseCnt <= '0;
        highReg  <= strobe.clearLvl ? CNT_MAX : '0;
        lowReg   <= strobe.clearLvl ? '0 : CNT_MAX;
      end else if (strobe.tick) begin
        if (strobe.rise) begin
          lowReg   <= phaseNext;
          phaseCnt <= '0;
        end else if (strobe.fall) begin
          highReg  <= phaseNext;
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseNext;
        end
      end
      // Sampled before the clear lands, so a same-cycle read sees old values.
      if (rdEn) rdQ <= {lowReg, highReg};
    end
  end

  p_clear_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear && !strobe.clearLvl) |=> (highReg == '0 && lowReg == CNT_MAX));

  p_clear_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear && strobe.clearLvl) |=> (highReg == CNT_MAX && lowReg == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rise && !strobe.fall && !strobe.clear) |=> ($stable(highReg) && $stable(lowReg)));

  p_read_old_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (rdData == {$past(lowReg), $past(highReg)}));

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.rise && !strobe.fall && !strobe.clear && phaseCnt == CNT_MAX)
      |=> (phaseCnt == CNT_MAX));

  p_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.rise || strobe.fall) && !strobe.clear) |=> (phaseCnt == '0));
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
  import pulse_meter_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sigIn,
  input  logic [DIV_W-1:0]     tickDiv,
  input  logic                 wrEn,
  input  logic [2*CNT_W-1:0]   wrData,
  input  logic                 rdEn,
  output logic [2*CNT_W-1:0]   rdData
);
  localparam int WORD_W = 2 * CNT_W;

  meter_strobe_t strobe;

  pulse_meter_ctrl #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sigIn   (sigIn),
    .tickDiv (tickDiv),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobe  (strobe)
  );

  pulse_meter_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdEn   (rdEn),
    .rdData (rdData)
  );
endmodule

// File: tb/pulse_meter_test.sv
`timescale 1ns/1ps
module pulse_meter_test;
  localparam int CNT_W  = 10;
  localparam int DIV_W  = 3;
  localparam int WORD_W = 2 * CNT_W;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sigIn = 1'b0;
  logic [DIV_W-1:0]  tickDiv = '0;
  logic              wrEn = 1'b0;
  logic [WORD_W-1:0] wrData = '0;
  logic              rdEn = 1'b0;
  logic [WORD_W-1:0] rdData;

  int totalCnt = 0;
  int passCnt  = 0;

  pulse_meter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .tickDiv(tickDiv),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );

  always #2.5 clk = ~clk;

  function automatic logic [CNT_W-1:0] satCnt(input int n);
    return (n >= int'(MAXV)) ? MAXV : CNT_W'(n);
  endfunction

  function automatic logic [WORD_W-1:0] packWord(input int hiTicks, input int loTicks);
    return {satCnt(loTicks), satCnt(hiTicks)};
  endfunction

  task automatic check(input string tag, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  task automatic readWord(output logic [WORD_W-1:0] v);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic writeWord(input logic [WORD_W-1:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  // Three full periods, ending with a rising edge and a settle while high.
  task automatic runPattern(input int h, input int l, input int d);
    tickDiv = DIV_W'(d);
    for (int p = 0; p < 3; p++) begin
      sigIn = 1'b1;
      repeat (h * (d + 1)) @(negedge clk);
      sigIn = 1'b0;
      repeat (l * (d + 1)) @(negedge clk);
    end
    sigIn = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    totalCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    logic [WORD_W-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readWord(v);
    check("R1 reset value", v, '0);

    // R2 R3 R4 R11: directed pattern, divide by 1
    runPattern(5, 12, 0);
    readWord(v);
    check("R2 R3 R4 packed high/low", v, packWord(5, 12));

    // R5: minimal phases at the slowest tick
    runPattern(1, 1, 7);
    readWord(v);
    check("R5 one tick each at divide by 8", v, packWord(1, 1));

    // R3 R4 R5 R11: random phases and divisors
    for (int t = 0; t < 14; t++) begin
      int h = int'($urandom_range(1, 60));
      int l = int'($urandom_range(1, 60));
      int d = int'($urandom_range(0, 7));
      runPattern(h, l, d);
      readWord(v);
      check("R3 R4 R5 random trial", v, packWord(h, l));
    end

    // R10: both phases longer than the counter range
    tickDiv = '0;
    sigIn = 1'b1; repeat (1100) @(negedge clk);
    sigIn = 1'b0; repeat (1200) @(negedge clk);
    sigIn = 1'b1; repeat (24) @(negedge clk);
    readWord(v);
    check("R10 saturation", v, packWord(1100, 1200));

    // R11: a short phase after saturated ones is measured on its own
    runPattern(3, 4, 0);
    readWord(v);
    check("R11 restart after saturation", v, packWord(3, 4));

    // R8: nonzero writes are ignored
    runPattern(5, 6, 2);
    writeWord(WORD_W'(20'h00F00));
    writeWord({1'b1, {(WORD_W-1){1'b0}}});
    writeWord(WORD_W'(1));
    repeat (5) @(negedge clk);
    readWord(v);
    check("R8 nonzero write ignored", v, packWord(5, 6));

    // R6: clear while low, then persistence with no edges
    sigIn = 1'b0; repeat (30) @(negedge clk);
    writeWord('0);
    readWord(v);
    check("R6 clear while low", v, {MAXV, {CNT_W{1'b0}}});
    repeat (100) @(negedge clk);
    readWord(v);
    check("R6 clear value persists", v, {MAXV, {CNT_W{1'b0}}});

    // R7: clear while high
    sigIn = 1'b1; repeat (30) @(negedge clk);
    writeWord('0);
    readWord(v);
    check("R7 clear while high", v, {{CNT_W{1'b0}}, MAXV});

    // R9: read and clear in the same cycle
    runPattern(7, 9, 1);
    rdEn = 1'b1; wrEn = 1'b1; wrData = '0;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    check("R9 same-cycle read sees old value", rdData, packWord(7, 9));
    readWord(v);
    check("R9 R7 value after same-cycle clear", v, {{CNT_W{1'b0}}, MAXV});

    // R1: reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData after reset", rdData, '0);

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule